// File: doc/BRIEF.md
# Shared-Bus Register Transfer Datapath

This block is the register file and word bus of a small 16-bit processor. Fifteen named registers share one data bus. No register drives the bus through a tri-state buffer. Instead, each register sits behind a connector stage, and the stages form a chain. A stage ORs its own register word into the running bus value when its connect bit is high, and passes the running value through unchanged otherwise. The head of the chain is seeded with zero, and the tail of the chain is the bus.

An external sequencer drives three vectors, each with one bit per register: load enables, connect selects and asynchronous clears. A register transfer takes one clock edge. In one cycle the sequencer selects a source onto the bus and raises the load enables of the destinations, and the destinations capture the bus value at the next rising edge. Ten registers load from the bus. The switch register, the ALU result register, the memory data register, the program counter and the instruction register load from their own input ports. The bus has no priority order. When two or more connect bits are raised, the bus carries the OR of the selected words and a flag reports the misuse.

Top module: `wordbus_datapath`

## Requirements
- R1: After reset, every register holds 0x0000, and `bus_o`, `led_o`, `disp_o`, `opa_o`, `opb_o`, `maddr_o` and `multi_sel_o` are all 0.
- R2: A register whose load enable is 0 keeps its value across clock edges, whatever its data source does.
- R3: Raising a register's bit in `clr_i` forces that register to 0x0000 at once, without waiting for a clock edge. The other registers are not affected.
- R4: The same bit index in `load_en_i`, `conn_sel_i` and `clr_i` names the same register: 0 to 4 are general registers G1 to G5, 5 is LED, 6 is switch, 7 is display, 8 is operand A, 9 is operand B, 10 is ALU result, 11 is memory address, 12 is memory data, 13 is program counter and 14 is instruction. With exactly one connect bit set, `bus_o` equals that register's value in the same cycle.
- R5: With no connect bit set, `bus_o` is 0x0000.
- R6: `multi_sel_o` is 1 in exactly the cycles in which two or more connect bits are set. In those cycles `bus_o` is the bitwise OR of the selected registers.
- R7: The switch register loads {8'h00, `sw_i`}, so its upper byte is always zero.
- R8: G1 to G5, LED, display, operand A, operand B and memory address load `bus_o` at the rising edge when enabled. A source register that is itself reloaded in the same cycle passes on its previous value, so each transfer has one cycle of latency.
- R9: The ALU result, memory data, program counter and instruction registers load `alu_res_i`, `mem_rd_i`, `pc_i` and `ir_i` respectively, and ignore the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load_en_i | input | 15 | Per-register load enable |
| conn_sel_i | input | 15 | Per-register bus connect select |
| clr_i | input | 15 | Per-register asynchronous clear |
| sw_i | input | 8 | Switch value for the switch register |
| alu_res_i | input | 16 | Data for the ALU result register |
| mem_rd_i | input | 16 | Data for the memory data register |
| pc_i | input | 16 | Data for the program counter |
| ir_i | input | 16 | Data for the instruction register |
| bus_o | output | 16 | Shared bus value |
| led_o | output | 16 | LED register |
| disp_o | output | 16 | Display register |
| opa_o | output | 16 | Operand A register |
| opb_o | output | 16 | Operand B register |
| maddr_o | output | 16 | Memory address register |
| multi_sel_o | output | 1 | Two or more connect bits set |

## Verification
The bus value and the multi-select flag are combinational. The bench checks them 1 ns after it changes `conn_sel_i`, with no clock edge in between. A load shows up after exactly one rising edge, so inputs change on the falling edge and load results are sampled at the next falling edge. A clear takes effect at once and is sampled 1 ns after it is raised. The bench reads registers that have no output port by selecting them onto the bus between edges, with every load enable held at 0.

// File: rtl/wordbus_pkg.sv
package wordbus_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned NUM_REGS = 15;
  localparam int unsigned SW_W     = 8;

  localparam int unsigned IDX_G1    = 0;
  localparam int unsigned IDX_G2    = 1;
  localparam int unsigned IDX_G3    = 2;
  localparam int unsigned IDX_G4    = 3;
  localparam int unsigned IDX_G5    = 4;
  localparam int unsigned IDX_LED   = 5;
  localparam int unsigned IDX_SW    = 6;
  localparam int unsigned IDX_DISP  = 7;
  localparam int unsigned IDX_OPA   = 8;
  localparam int unsigned IDX_OPB   = 9;
  localparam int unsigned IDX_RES   = 10;
  localparam int unsigned IDX_MADDR = 11;
  localparam int unsigned IDX_MDATA = 12;
  localparam int unsigned IDX_PC    = 13;
  localparam int unsigned IDX_IR    = 14;

  // Register slots whose data input is the shared bus.
  function automatic bit is_bus_fed(int unsigned idx);
    return (idx <= IDX_LED) || (idx == IDX_DISP) || (idx == IDX_OPA) ||
           (idx == IDX_OPB) || (idx == IDX_MADDR);
  endfunction
endpackage

// File: rtl/wordbus_rstsync.sv
module wordbus_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/wordbus_reg.sv
module wordbus_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (ce) q_nxt = d;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= q_nxt;
  end
endmodule

// File: rtl/wordbus_conn.sv
module wordbus_conn #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] chain_in,
  input  logic [W-1:0] reg_val,
  input  logic         connect,
  output logic [W-1:0] chain_out
);
  assign chain_out = chain_in | (reg_val & {W{connect}});
endmodule

// File: rtl/wordbus_selchk.sv
module wordbus_selchk #(
  parameter int unsigned N = 15
) (
  input  logic [N-1:0] sel,
  output logic         dup
);
  logic seen;

  always_comb begin
    seen = 1'b0;
    dup  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel[i]) begin
        if (seen) dup = 1'b1;
        seen = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wordbus_datapath.sv
module wordbus_datapath
  import wordbus_pkg::*;
#(
  parameter int unsigned W    = WORD_W,
  parameter int unsigned SWW  = SW_W,
  parameter int unsigned NREG = NUM_REGS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] load_en_i,
  input  logic [NREG-1:0] conn_sel_i,
  input  logic [NREG-1:0] clr_i,
  input  logic [SWW-1:0]  sw_i,
  input  logic [W-1:0]    alu_res_i,
  input  logic [W-1:0]    mem_rd_i,
  input  logic [W-1:0]    pc_i,
  input  logic [W-1:0]    ir_i,
  output logic [W-1:0]    bus_o,
  output logic [W-1:0]    led_o,
  output logic [W-1:0]    disp_o,
  output logic [W-1:0]    opa_o,
  output logic [W-1:0]    opb_o,
  output logic [W-1:0]    maddr_o,
  output logic            multi_sel_o
);
  localparam int unsigned PAD_W = W - SWW;

  logic                  srst_n;
  logic [NREG-1:0][W-1:0] q_all;
  logic [NREG-1:0][W-1:0] d_all;
  logic [W-1:0]           chain [NREG+1];
  logic [W-1:0]           bus;

  wordbus_rstsync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign chain[0] = '0;

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    logic slot_rst_n;
    assign slot_rst_n = srst_n & ~clr_i[i];

    if (is_bus_fed(i)) begin : g_src_bus
      assign d_all[i] = bus;
    end else if (i == IDX_SW) begin : g_src_sw
      assign d_all[i] = {{PAD_W{1'b0}}, sw_i};
    end else if (i == IDX_RES) begin : g_src_res
      assign d_all[i] = alu_res_i;
    end else if (i == IDX_MDATA) begin : g_src_mdata
      assign d_all[i] = mem_rd_i;
    end else if (i == IDX_PC) begin : g_src_pc
      assign d_all[i] = pc_i;
    end else begin : g_src_ir
      assign d_all[i] = ir_i;
    end

    wordbus_reg #(.W(W)) u_reg (
      .clk    (clk),
      .arst_n (slot_rst_n),
      .ce     (load_en_i[i]),
      .d      (d_all[i]),
      .q      (q_all[i])
    );

    wordbus_conn #(.W(W)) u_conn (
      .chain_in  (chain[i]),
      .reg_val   (q_all[i]),
      .connect   (conn_sel_i[i]),
      .chain_out (chain[i+1])
    );
  end

  assign bus = chain[NREG];

  wordbus_selchk #(.N(NREG)) u_selchk (
    .sel (conn_sel_i),
    .dup (multi_sel_o)
  );

  assign bus_o   = bus;
  assign led_o   = q_all[IDX_LED];
  assign disp_o  = q_all[IDX_DISP];
  assign opa_o   = q_all[IDX_OPA];
  assign opb_o   = q_all[IDX_OPB];
  assign maddr_o = q_all[IDX_MADDR];
endmodule

// File: rtl/wordbus_chk.sv
module wordbus_chk
  import wordbus_pkg::*;
#(
  parameter int unsigned W    = WORD_W,
  parameter int unsigned NREG = NUM_REGS
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREG-1:0] load_en_i,
  input logic [NREG-1:0] conn_sel_i,
  input logic [NREG-1:0] clr_i,
  input logic [W-1:0]    bus_o,
  input logic [W-1:0]    led_o,
  input logic [W-1:0]    disp_o,
  input logic            multi_sel_o
);
  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (conn_sel_i == '0) |-> (bus_o == '0));

  assert_multi_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(conn_sel_i) > 1) |-> multi_sel_o);

  assert_single_noflag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(conn_sel_i) |-> !multi_sel_o);

  assert_led_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en_i[IDX_LED] && !clr_i[IDX_LED]) |=>
      (clr_i[IDX_LED] || led_o == $past(bus_o)));

  assert_disp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en_i[IDX_DISP] && !clr_i[IDX_DISP]) |=>
      (clr_i[IDX_DISP] || $stable(disp_o)));

  assert_led_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i[IDX_LED] |-> (led_o == '0));
endmodule

bind wordbus_datapath wordbus_chk #(.W(W), .NREG(NREG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_en_i   (load_en_i),
  .conn_sel_i  (conn_sel_i),
  .clr_i       (clr_i),
  .bus_o       (bus_o),
  .led_o       (led_o),
  .disp_o      (disp_o),
  .multi_sel_o (multi_sel_o)
);

// File: tb/sim_wordbus_datapath.sv
`timescale 1ns/1ps
module sim_wordbus_datapath;
  import wordbus_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [14:0] load_en, conn_sel, clr;
  logic [7:0]  sw;
  logic [15:0] alu_res, mem_rd, pc, ir;
  logic [15:0] bus, led, disp, opa, opb, maddr;
  logic        multi;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  wordbus_datapath u0 (
    .clk(clk), .rst_n(rst_n), .load_en_i(load_en), .conn_sel_i(conn_sel),
    .clr_i(clr), .sw_i(sw), .alu_res_i(alu_res), .mem_rd_i(mem_rd),
    .pc_i(pc), .ir_i(ir), .bus_o(bus), .led_o(led), .disp_o(disp),
    .opa_o(opa), .opb_o(opb), .maddr_o(maddr), .multi_sel_o(multi)
  );

  function automatic logic [14:0] bit_of(int unsigned idx);
    return 15'(1) << idx;
  endfunction

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Read a register through the bus between edges; load enables stay low.
  task automatic peek(int unsigned idx, output logic [15:0] v);
    conn_sel = bit_of(idx);
    #1 v = bus;
    conn_sel = '0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int i = 0; i < 15; i++) begin
      peek(i, v);
      chk($sformatf("R1 reg %0d after reset", i), v, 16'h0000);
    end
    chk("R1 led", led, 16'h0); chk("R1 disp", disp, 16'h0);
    chk("R1 opa/opb/maddr", opa | opb | maddr, 16'h0);
    chk("R1 multi flag", {15'd0, multi}, 16'h0);
  endtask

  task automatic t_load_hold();
    logic [15:0] v;
    ir = 16'hA5C3; load_en = bit_of(IDX_IR);
    @(negedge clk); load_en = '0;
    peek(IDX_IR, v); chk("R9 instruction from port", v, 16'hA5C3);
    conn_sel = bit_of(IDX_IR); load_en = bit_of(IDX_G3);
    @(negedge clk); conn_sel = '0; load_en = '0;
    peek(IDX_G3, v); chk("R8 G3 from bus", v, 16'hA5C3);
    ir = 16'h1111;
    @(negedge clk);
    peek(IDX_IR, v); chk("R2 instruction held", v, 16'hA5C3);
    peek(IDX_G3, v); chk("R2 G3 held", v, 16'hA5C3);
  endtask

  task automatic t_nonbus();
    logic [15:0] v;
    conn_sel = bit_of(IDX_IR); alu_res = 16'h7E01; load_en = bit_of(IDX_RES);
    @(negedge clk); conn_sel = '0; load_en = '0;
    peek(IDX_RES, v); chk("R9 ALU result ignores bus", v, 16'h7E01);
  endtask

  task automatic t_operands();
    conn_sel = bit_of(IDX_RES);
    load_en  = bit_of(IDX_OPA) | bit_of(IDX_OPB) | bit_of(IDX_MADDR);
    @(negedge clk); conn_sel = '0; load_en = '0;
    chk("R8 operand A", opa, 16'h7E01);
    chk("R8 operand B", opb, 16'h7E01);
    chk("R8 memory address", maddr, 16'h7E01);
  endtask

  task automatic t_pipe();
    sw = 8'h12; conn_sel = bit_of(IDX_SW);
    load_en = bit_of(IDX_SW) | bit_of(IDX_LED) | bit_of(IDX_DISP);
    @(negedge clk);
    chk("R8 led gets old switch value", led, 16'h0000);
    chk("R7 switch on bus", bus, 16'h0012);
    sw = 8'hF4;
    @(negedge clk);
    chk("R8 led one cycle late", led, 16'h0012);
    chk("R8 disp one cycle late", disp, 16'h0012);
    chk("R7 switch upper byte zero", bus, 16'h00F4);
    @(negedge clk);
    chk("R8 led second word", led, 16'h00F4);
    conn_sel = '0; load_en = '0;
  endtask

  task automatic t_idle();
    #1;
    chk("R5 idle bus", bus, 16'h0000);
    chk("R5 no flag", {15'd0, multi}, 16'h0);
  endtask

  task automatic t_multi();
    pc = 16'h0F00; mem_rd = 16'h00F0;
    load_en = bit_of(IDX_PC) | bit_of(IDX_MDATA);
    @(negedge clk); load_en = '0;
    conn_sel = bit_of(IDX_PC) | bit_of(IDX_MDATA);
    #1;
    chk("R6 OR of two", bus, 16'h0FF0);
    chk("R6 flag set", {15'd0, multi}, 16'h1);
    conn_sel = bit_of(IDX_PC);
    #1;
    chk("R4 single select", bus, 16'h0F00);
    chk("R6 flag clear", {15'd0, multi}, 16'h0);
    conn_sel = '0;
    @(negedge clk);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    clr = bit_of(IDX_LED);
    #1 chk("R3 led cleared without edge", led, 16'h0000);
    peek(IDX_DISP, v); chk("R3 disp untouched", v, 16'h00F4);
    clr = '0;
    @(negedge clk);
    chk("R3 led stays clear", led, 16'h0000);
  endtask

  initial begin
    rst_n = 1'b0; load_en = '0; conn_sel = '0; clr = '0; sw = '0;
    alu_res = '0; mem_rd = '0; pc = '0; ir = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_load_hold();
    t_nonbus();
    t_operands();
    t_pipe();
    t_idle();
    t_multi();
    t_clear();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule